// File: doc/BRIEF.md
# Per-Class Credit Based Traffic Shaper

This block paces transmit traffic classes on one Ethernet port. Each class has a signed credit counter and a registered transmit-eligible flag. An external strict-priority selector uses the flag to decide which classes may start a frame. Credit builds up while a class has frames waiting and is blocked. It drains while the class sends. A class may start only when its credit is zero or above. Over a long run, a shaped class therefore gets the share of line time it has reserved.

Software programs each class through two 32-bit words: a control word (an enable bit and a whole-number bandwidth percentage) and a credit ceiling. Only the two highest-numbered classes can be shaped. The register logic refuses any configuration that breaks the ordering rules or over-commits the port, and it pulses an error flag when it does. Credit is counted in the units of the ceiling register, which scale the ceiling by the reference clock frequency times 100 over the port rate. In these units one clock tick adds exactly the percentage and removes exactly 100 minus the percentage. The port rate cancels out of the per-tick arithmetic.

Top module: `cbs_shaper`

## Requirements
- R1: After reset every bit of `tx_eligible` is 1, `cfg_err` is 0 and every register reads 0.
- R2: For class n, the control word sits at byte address 0x1110+8n and the ceiling word at 0x1114+8n. Control bit 31 is the enable and bits 6:0 are the percentage; the other control bits read as 0. `cfg_rdata` returns the word at `cfg_addr` one clock later.
- R3: Only classes N-1 and N-2 are shapeable. Writes to any other class are ignored and that class reads 0. A control write with bit 31 set to such a class raises `cfg_err` for one cycle after the write.
- R4: Enabling class N-2 while class N-1 is disabled is rejected: the register is unchanged and `cfg_err` pulses.
- R5: Disabling class N-1 while class N-2 is enabled is rejected in the same way.
- R6: A control write that would leave the enabled percentages summing to 100 or more is rejected in the same way. This includes a single class at 100 or more.
- R7: A control write of 0 disables a class. From the next credit update on, the class is eligible, whatever credit it held.
- R8: A disabled class holds zero credit and is always eligible.
- R9: While an enabled class has `q_pending` set and `tx_active` clear, its credit rises by the percentage each clock and never exceeds the ceiling.
- R10: While an enabled class has `tx_active` set, its credit falls by 100 minus the percentage each clock.
- R11: With neither `q_pending` nor `tx_active`, positive credit drops to 0 on the next clock, and negative credit rises by the percentage each clock up to 0.
- R12: For an enabled class, `tx_eligible` is 1 exactly when the credit just computed is zero or above. It is registered in the same clock as the credit.
- R13: With a continuous backlog and a transmitter that starts a frame whenever the class is eligible, the class is busy for its percentage of the time within 3 percentage points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shaper clock, one credit update per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Byte address for both write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| cfg_err | output | 1 | One-cycle pulse after a refused write |
| q_pending | input | NUM_CLS | Per class: frames are waiting |
| tx_active | input | NUM_CLS | Per class: a frame is being sent this tick |
| tx_eligible | output | NUM_CLS | Per class: may start a frame |

## Verification
Credit is hidden state, so any fault in it shows up only as a shift in when `tx_eligible` falls or rises. A ceiling that fails to clamp, a wrong slope or a missed reset to zero each move the eligibility edge by whole ticks at a known cycle. The bench times those edges exactly after controlled pending, sending and idle phases. A broken rule check in the register logic shows one cycle after the write, in `cfg_err` and in the next readback. Slow drift in the slopes shows only as a wrong share of busy time over thousands of cycles, which the long-run rate measurement catches.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int REG_W  = 32;
  localparam int BW_W   = 7;
  localparam int EN_BIT = 31;

  typedef struct packed {
    logic            en;
    logic [BW_W-1:0] bw;
  } cls_ctrl_t;
endpackage

// File: rtl/cbs_regfile.sv
module cbs_regfile import cbs_pkg::*; #(
  parameter int                NUM_CLS   = 8,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1110,
  parameter int                HI_W      = 32,
  parameter int                PCT_FULL  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata_o,
  output logic              err_o,
  output cls_ctrl_t         ctrl_o [NUM_CLS],
  output logic [HI_W-1:0]   hi_o   [NUM_CLS]
);
  localparam int CLS_W  = $clog2(NUM_CLS);
  localparam int STRIDE = 8;
  localparam int SPAN   = NUM_CLS * STRIDE;
  localparam int TOP    = NUM_CLS - 1;
  localparam int NXT    = NUM_CLS - 2;
  localparam int SUM_W  = BW_W + 1;

  logic [ADDR_W-1:0] off;
  logic              hit, is_hi, shapeable, to_top, new_en, wr_ok, wr_bad;
  logic [CLS_W-1:0]  sel;
  logic [BW_W-1:0]   new_bw;
  logic [SUM_W-1:0]  sum_top, sum_nxt;
  logic [REG_W-1:0]  rd_word;
  cls_ctrl_t         new_ctrl;

  // address decode shared by read and write
  assign off       = addr - BASE_ADDR;
  assign hit       = (addr >= BASE_ADDR) && (off < ADDR_W'(SPAN)) && (off[1:0] == 2'b00);
  assign sel       = off[CLS_W+2:3];
  assign is_hi     = off[2];
  assign to_top    = (sel == CLS_W'(TOP));
  assign shapeable = to_top || (sel == CLS_W'(NXT));
  assign new_en    = wdata[EN_BIT];
  assign new_bw    = wdata[BW_W-1:0];
  assign new_ctrl  = '{en: new_en, bw: new_bw};

  // bandwidth totals the write would leave behind
  assign sum_top = {1'b0, new_bw} + (ctrl_o[NXT].en ? {1'b0, ctrl_o[NXT].bw} : '0);
  assign sum_nxt = {1'b0, new_bw} + {1'b0, ctrl_o[TOP].bw};

  always_comb begin
    wr_ok  = 1'b0;
    wr_bad = 1'b0;
    if (we && hit) begin
      if (!shapeable) begin
        wr_bad = new_en && !is_hi;
      end else begin
        if (is_hi)
          wr_ok = 1'b1;
        else if (to_top)
          wr_ok = new_en ? (sum_top < SUM_W'(PCT_FULL)) : !ctrl_o[NXT].en;
        else
          wr_ok = new_en ? (ctrl_o[TOP].en && (sum_nxt < SUM_W'(PCT_FULL))) : 1'b1;
        wr_bad = !wr_ok;
      end
    end
  end

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
    if (i >= NXT) begin : g_shaped
      cls_ctrl_t       c_q;
      logic [HI_W-1:0] h_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          c_q <= '0;
          h_q <= '0;
        end else if (wr_ok && (sel == CLS_W'(i))) begin
          if (is_hi) h_q <= wdata[HI_W-1:0];
          else       c_q <= new_ctrl;
        end
      end
      assign ctrl_o[i] = c_q;
      assign hi_o[i]   = h_q;
    end else begin : g_fixed
      assign ctrl_o[i] = '0;
      assign hi_o[i]   = '0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit) begin
      if (is_hi) begin
        rd_word[HI_W-1:0] = hi_o[sel];
      end else begin
        rd_word[EN_BIT]    = ctrl_o[sel].en;
        rd_word[BW_W-1:0]  = ctrl_o[sel].bw;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rd_word;
      err_o   <= wr_bad;
    end
  end

  // R4
  shape_order_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_o[NXT].en |-> ctrl_o[TOP].en);

  // R6
  bw_budget_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_o[TOP].en |-> (({1'b0, ctrl_o[TOP].bw} +
      (ctrl_o[NXT].en ? {1'b0, ctrl_o[NXT].bw} : '0)) < SUM_W'(PCT_FULL)));

  // R5
  refused_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && hit && shapeable && !wr_ok) |=>
      ($stable(ctrl_o[TOP]) && $stable(ctrl_o[NXT]) && err_o));
endmodule

// File: rtl/cbs_credit.sv
module cbs_credit import cbs_pkg::*; #(
  parameter int HI_W     = 32,
  parameter int CRED_W   = 34,
  parameter int PCT_FULL = 100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [BW_W-1:0] bw,
  input  logic [HI_W-1:0] hi,
  input  logic            pend,
  input  logic            tx,
  output logic            elig_o
);
  logic signed [CRED_W-1:0] cred_q, cred_d, up, down, ceil, raised;

  assign ceil   = $signed({{(CRED_W-HI_W){1'b0}}, hi});
  assign up     = $signed({{(CRED_W-BW_W){1'b0}}, bw});
  assign down   = $signed(CRED_W'(PCT_FULL)) - up;
  assign raised = cred_q + up;

  always_comb begin
    if (!en)             cred_d = '0;
    else if (tx)         cred_d = cred_q - down;
    else if (pend)       cred_d = raised;
    else if (cred_q > 0) cred_d = '0;
    else                 cred_d = (raised > 0) ? '0 : raised;
    if (cred_d > ceil)   cred_d = ceil;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cred_q <= '0;
      elig_o <= 1'b1;
    end else begin
      cred_q <= cred_d;
      elig_o <= !en || (cred_d >= 0);
    end
  end

  // R9
  ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en) |-> (cred_q <= $past(ceil)));

  // R8
  unshaped_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (elig_o && (cred_q == 0)));

  // R11
  idle_credit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en && !tx && !pend) |-> (cred_q <= 0));

  // R10
  send_drain_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en && tx && (bw < BW_W'(PCT_FULL))) |-> (cred_q < $past(cred_q)));
endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper import cbs_pkg::*; #(
  parameter int                NUM_CLS   = 8,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1110,
  parameter int                HI_W      = 32,
  parameter int                CRED_W    = 34,
  parameter int                PCT_FULL  = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  output logic               cfg_err,
  input  logic [NUM_CLS-1:0] q_pending,
  input  logic [NUM_CLS-1:0] tx_active,
  output logic [NUM_CLS-1:0] tx_eligible
);
  cls_ctrl_t       ctrl [NUM_CLS];
  logic [HI_W-1:0] hi   [NUM_CLS];

  cbs_regfile #(
    .NUM_CLS(NUM_CLS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .HI_W(HI_W), .PCT_FULL(PCT_FULL)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata_o(cfg_rdata), .err_o(cfg_err), .ctrl_o(ctrl), .hi_o(hi)
  );

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_class
    cbs_credit #(
      .HI_W(HI_W), .CRED_W(CRED_W), .PCT_FULL(PCT_FULL)
    ) u_credit (
      .clk(clk), .rst(rst), .en(ctrl[i].en), .bw(ctrl[i].bw), .hi(hi[i]),
      .pend(q_pending[i]), .tx(tx_active[i]), .elig_o(tx_eligible[i])
    );
  end
endmodule

// File: tb/cbs_shaper_tb.sv
module cbs_shaper_tb;
  localparam int N = 8;
  localparam logic [15:0] BASE = 16'h1110;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic [N-1:0] q_pending = '0;
  logic [N-1:0] tx_active = '0;
  logic [N-1:0] tx_eligible;

  always #5 clk = ~clk;

  cbs_shaper u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .q_pending(q_pending), .tx_active(tx_active), .tx_eligible(tx_eligible)
  );

  typedef struct { string req; logic [31:0] exp; } exp_t;
  exp_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [15:0] a_ctrl(input int c); return BASE + 16'(8 * c); endfunction
  function automatic logic [15:0] a_hi(input int c);   return BASE + 16'(8 * c + 4); endfunction

  // driver side: queue the expectation
  task automatic expect_v(input string req, input logic [31:0] e);
    sb_q.push_back('{req, e});
  endtask

  // monitor side: pop the oldest expectation and compare
  task automatic observe(input logic [31:0] act);
    exp_t it;
    n_checks++;
    if (sb_q.size() == 0) begin
      n_fail++;
      $display("FAIL none: unexpected result act=%h exp=nothing", act);
    end else begin
      it = sb_q.pop_front();
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: act=%h exp=%h", it.req, act, it.exp);
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] e);
    expect_v(req, e);
    observe(act);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, output logic e);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    e = cfg_err;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: act=expired exp=finished");
    report();
  end

  initial begin
    logic        e;
    logic [31:0] d;
    int          busy, left;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", {24'b0, tx_eligible}, 32'h0000_00FF);
    chk("R1", {31'b0, cfg_err}, 32'h0);
    rd(a_ctrl(7), d); chk("R1", d, 32'h0);
    rd(a_hi(7), d);   chk("R1", d, 32'h0);

    // R3 unshapeable class
    wr(a_ctrl(2), 32'h8000_000A, e); chk("R3", {31'b0, e}, 32'h1);
    rd(a_ctrl(2), d); chk("R3", d, 32'h0);

    // R4 second class before top
    wr(a_ctrl(6), 32'h8000_0014, e); chk("R4", {31'b0, e}, 32'h1);
    rd(a_ctrl(6), d); chk("R4", d, 32'h0);

    // R6 single class at 100
    wr(a_ctrl(7), 32'h8000_0064, e); chk("R6", {31'b0, e}, 32'h1);
    rd(a_ctrl(7), d); chk("R6", d, 32'h0);

    // R2 configure top: 25 percent, ceiling 300, reserved bits dropped
    wr(a_hi(7), 32'd300, e);         chk("R2", {31'b0, e}, 32'h0);
    wr(a_ctrl(7), 32'h8000_FF19, e); chk("R2", {31'b0, e}, 32'h0);
    rd(a_ctrl(7), d); chk("R2", d, 32'h8000_0019);
    rd(a_hi(7), d);   chk("R2", d, 32'd300);

    // R6 sum 100 refused, sum 99 accepted
    wr(a_ctrl(6), 32'h8000_004B, e); chk("R6", {31'b0, e}, 32'h1);
    rd(a_ctrl(6), d); chk("R6", d, 32'h0);
    wr(a_ctrl(6), 32'h8000_004A, e); chk("R6", {31'b0, e}, 32'h0);
    rd(a_ctrl(6), d); chk("R6", d, 32'h8000_004A);
    wr(a_ctrl(6), 32'h0, e);         chk("R7", {31'b0, e}, 32'h0);

    // R5 top may not go first
    wr(a_ctrl(6), 32'h8000_000A, e); chk("R5", {31'b0, e}, 32'h0);
    wr(a_ctrl(7), 32'h0, e);         chk("R5", {31'b0, e}, 32'h1);
    rd(a_ctrl(7), d); chk("R5", d, 32'h8000_0019);
    wr(a_ctrl(6), 32'h0, e);         chk("R5", {31'b0, e}, 32'h0);

    // R9 rise to the ceiling of 300, then R10 drain 75 per tick
    q_pending[7] = 1'b1;
    repeat (20) @(negedge clk);
    tx_active[7] = 1'b1; tx_active[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", {31'b0, tx_eligible[7]}, 32'h1);
    @(negedge clk);
    chk("R9", {31'b0, tx_eligible[7]}, 32'h0);
    chk("R8", {31'b0, tx_eligible[0]}, 32'h1);
    tx_active[7] = 1'b0;
    // credit -75, rising 25 per tick while pending
    repeat (2) @(negedge clk);
    chk("R12", {31'b0, tx_eligible[7]}, 32'h0);
    @(negedge clk);
    chk("R12", {31'b0, tx_eligible[7]}, 32'h1);
    // R11 negative credit climbs back while idle
    tx_active[7] = 1'b1;
    repeat (2) @(negedge clk);
    tx_active[7] = 1'b0; q_pending[7] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11", {31'b0, tx_eligible[7]}, 32'h0);
    @(negedge clk);
    chk("R11", {31'b0, tx_eligible[7]}, 32'h1);
    // R11 positive credit dropped to zero when the queue empties
    q_pending[7] = 1'b1;
    repeat (4) @(negedge clk);
    q_pending[7] = 1'b0;
    @(negedge clk);
    tx_active[7] = 1'b1;
    @(negedge clk);
    chk("R11", {31'b0, tx_eligible[7]}, 32'h0);

    // R7 disabling while in debt makes the class eligible at once
    wr(a_ctrl(7), 32'h0, e); chk("R7", {31'b0, e}, 32'h0);
    @(negedge clk);
    chk("R7", {31'b0, tx_eligible[7]}, 32'h1);
    tx_active[7] = 1'b0; tx_active[0] = 1'b0;
    rd(a_ctrl(7), d); chk("R7", d, 32'h0);

    // R13 long-run share with 40-tick frames at 25 percent
    wr(a_hi(7), 32'h0001_0000, e);
    wr(a_ctrl(7), 32'h8000_0019, e);
    q_pending[7] = 1'b1;
    busy = 0; left = 0;
    for (int t = 0; t < 20000; t++) begin
      if (left == 0 && tx_eligible[7]) left = 40;
      tx_active[7] = (left > 0);
      if (left > 0) begin busy++; left--; end
      @(negedge clk);
    end
    tx_active[7] = 1'b0; q_pending[7] = 1'b0;
    chk("R13", {31'b0, (busy >= 4400 && busy <= 5600)}, 32'h1);

    report();
  end
endmodule